// File: doc/BRIEF.md
# Serial Memory Read Address Pointer

This block keeps the internal address counter of a byte-serial memory whose address space is 2^ADDR_W bytes (11 bits by default). A bit-level bus front end feeds it decoded events: start or repeated start, stop, a received byte, and the master's acknowledge or non-acknowledge after each byte sent out. From these it tracks the transfer in progress. It loads the counter from a two-byte word address that follows a write-mode target byte. It asks the storage for one byte each time the master wants more read data.

Data can be read in three ways. A random read sends the word address, then a repeated start and a read-mode target byte. A set-address operation sends the same word address but ends with a stop, which leaves the counter loaded for later. A current-address read sends a read-mode target byte alone. Each master acknowledge steps the pointer on, across the whole array, wrapping from the top address to zero. A non-acknowledge ends the read. The storage array and the serial timing are outside this block.

Top module: `read_addr_ptr`

## Requirements
- R1: During and right after synchronous reset, bus_idle is 1, rd_valid is 0 and fetch_addr is 0.
- R2: Random read works as follows. Start, target byte {DEV_ID, 0}, word high byte, word low byte, repeated start, target byte {DEV_ID, 1}. One cycle after the last byte, rd_valid pulses and fetch_addr equals the word address.
- R3: The set-address operation is the same sequence with a stop in place of the repeated start. It leaves bus_idle at 1 and the counter loaded, and a later current-address read fetches from that address.
- R4: A current-address read is a start and then {DEV_ID, 1} (the read/write flag is bit 0, 1 meaning read). It pulses rd_valid one cycle later with fetch_addr at the counter's present value.
- R5: During a read, each master acknowledge advances fetch_addr by one and pulses rd_valid one cycle later. The counter wraps from 2^ADDR_W-1 to 0.
- R6: A master non-acknowledge ends the read. The counter advances by one without pulsing rd_valid. Later acknowledges are ignored until a new start, and the next current-address read continues from the advanced value.
- R7: The word address is sent high byte first. Only the low ADDR_W-8 bits of the high byte are used, and its upper bits are ignored.
- R8: A start that arrives before the word address is complete drops the operation, and the counter keeps its old value.
- R9: A target byte whose upper 7 bits differ from DEV_ID sends the block to idle (bus_idle 1). It leaves the counter unchanged and produces no rd_valid.
- R10: After a stop the block is idle. While idle, every event other than a start (bytes, acknowledges, stops) is ignored, and rd_valid stays 0.
- R11: rd_valid is a single-cycle pulse. It is 0 in any cycle that does not follow a read-mode target byte or an acknowledge during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen (one-cycle pulse) |
| ev_byte | input | 1 | A byte from the master is in byte_data |
| byte_data | input | 8 | Received byte |
| ev_ack | input | 1 | Master acknowledged the byte just sent |
| ev_nack | input | 1 | Master did not acknowledge the byte just sent |
| fetch_addr | output | ADDR_W | Current pointer, the address to fetch |
| rd_valid | output | 1 | Fetch strobe: a data byte at fetch_addr is needed |
| bus_idle | output | 1 | Block is waiting for a start and ignoring the bus |

## Verification
A wrong pointer shows on fetch_addr one cycle after the read-mode target byte that follows it, so each loaded address gets checked at its first use. A stuck or misrouted control state shows up in one of two ways, one cycle after the event. The block may raise rd_valid where none is due, such as after a non-acknowledge, while idle, or after a foreign target byte. Or it may fail to return bus_idle after a stop. A counter that wraps or carries wrongly shows up at the first acknowledge that crosses the boundary.

// File: rtl/rdptr_pkg.sv
package rdptr_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_TARGET,
        PS_WHI,
        PS_WLO,
        PS_ADDRSET,
        PS_READ,
        PS_DRAIN
    } ptr_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_START,
        EV_STOP,
        EV_BYTE,
        EV_ACK,
        EV_NACK
    } bus_ev_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic byte_v;
        logic ack;
        logic nack;
    } bus_ev_t;

    // One event per cycle is expected; if several come together, start wins.
    function automatic bus_ev_e pick_event(input bus_ev_t e);
        if (e.start)       return EV_START;
        else if (e.stop)   return EV_STOP;
        else if (e.byte_v) return EV_BYTE;
        else if (e.ack)    return EV_ACK;
        else if (e.nack)   return EV_NACK;
        else               return EV_NONE;
    endfunction

    function automatic logic id_match(input logic [7:0] b, input logic [6:0] id);
        return b[7:1] == id;
    endfunction

endpackage

// File: rtl/rdptr_counter.sv
module rdptr_counter #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              incr,
    output logic [ADDR_W-1:0] q
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Natural modulo-2^ADDR_W wrap: top address steps to zero.
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= load_val;
        else if (incr) q <= q + ONE;
    end
endmodule

// File: rtl/rdptr_ctrl.sv
module rdptr_ctrl
    import rdptr_pkg::*;
#(
    parameter int         ADDR_W = 11,
    parameter logic [6:0] DEV_ID = 7'h6F
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_e           ev,
    input  logic [7:0]        data,
    output logic              load,
    output logic [ADDR_W-1:0] load_val,
    output logic              incr,
    output logic              fire,
    output logic              idle
);
    localparam int HI_W = ADDR_W - 8;

    ptr_state_e          state_q, state_d;
    logic [HI_W-1:0]     hi_q, hi_d;

    always_comb begin
        state_d  = state_q;
        hi_d     = hi_q;
        load     = 1'b0;
        load_val = {hi_q, data};
        incr     = 1'b0;
        fire     = 1'b0;
        unique case (ev)
            EV_START: state_d = PS_TARGET;
            EV_STOP:  state_d = PS_IDLE;
            EV_BYTE: begin
                case (state_q)
                    PS_TARGET: begin
                        if (!id_match(data, DEV_ID)) begin
                            state_d = PS_IDLE;
                        end else if (data[0]) begin
                            state_d = PS_READ;
                            fire    = 1'b1;
                        end else begin
                            state_d = PS_WHI;
                        end
                    end
                    PS_WHI: begin
                        hi_d    = data[HI_W-1:0];
                        state_d = PS_WLO;
                    end
                    PS_WLO: begin
                        load    = 1'b1;
                        state_d = PS_ADDRSET;
                    end
                    default: ;
                endcase
            end
            EV_ACK: begin
                if (state_q == PS_READ) begin
                    incr = 1'b1;
                    fire = 1'b1;
                end
            end
            EV_NACK: begin
                if (state_q == PS_READ) begin
                    incr    = 1'b1;
                    state_d = PS_DRAIN;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            hi_q    <= hi_d;
        end
    end

    assign idle = (state_q == PS_IDLE);
endmodule

// File: rtl/read_addr_ptr.sv
module read_addr_ptr
    import rdptr_pkg::*;
#(
    parameter int         ADDR_W = 11,
    parameter logic [6:0] DEV_ID = 7'h6F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [7:0]        byte_data,
    input  logic              ev_ack,
    input  logic              ev_nack,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              rd_valid,
    output logic              bus_idle
);
    bus_ev_t           ev_bus;
    bus_ev_e           ev_kind;
    logic              ld, inc, fire;
    logic [ADDR_W-1:0] ld_val;

    assign ev_bus  = '{start: ev_start, stop: ev_stop, byte_v: ev_byte,
                       ack: ev_ack, nack: ev_nack};
    assign ev_kind = pick_event(ev_bus);

    rdptr_ctrl #(.ADDR_W(ADDR_W), .DEV_ID(DEV_ID)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev_kind),
        .data     (byte_data),
        .load     (ld),
        .load_val (ld_val),
        .incr     (inc),
        .fire     (fire),
        .idle     (bus_idle)
    );

    rdptr_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .incr     (inc),
        .q        (fetch_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= fire;
    end
endmodule

// File: rtl/rdptr_chk.sv
module rdptr_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_start,
    input logic              ev_stop,
    input logic              ev_byte,
    input logic              ev_ack,
    input logic              ev_nack,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              rd_valid,
    input logic              bus_idle
);
    // R11
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(ev_byte || ev_ack));

    // R5
    ack_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ev_ack) && rd_valid) |-> fetch_addr == ADDR_W'($past(fetch_addr) + 1'b1));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_idle && !ev_start) |=> (bus_idle && !rd_valid));

    // R10
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_stop && !ev_start) |=> bus_idle);

    // R8
    ptr_change_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(fetch_addr) |-> $past(ev_byte || ev_ack || ev_nack));
endmodule

bind read_addr_ptr rdptr_chk #(.ADDR_W(ADDR_W)) u_rdptr_chk (
    .clk        (clk),
    .rst        (rst),
    .ev_start   (ev_start),
    .ev_stop    (ev_stop),
    .ev_byte    (ev_byte),
    .ev_ack     (ev_ack),
    .ev_nack    (ev_nack),
    .fetch_addr (fetch_addr),
    .rd_valid   (rd_valid),
    .bus_idle   (bus_idle)
);

// File: tb/read_addr_ptr_bench.sv
module read_addr_ptr_bench;
    localparam int         AW  = 11;
    localparam logic [6:0] ID  = 7'h6F;
    localparam int         TOP = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ev_start = 0, ev_stop = 0, ev_byte = 0, ev_ack = 0, ev_nack = 0;
    logic [7:0]    byte_data = '0;
    logic [AW-1:0] fetch_addr;
    logic          rd_valid, bus_idle;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr = 0;

    always #2 clk = ~clk;

    read_addr_ptr #(.ADDR_W(AW), .DEV_ID(ID)) u_read_addr_ptr (
        .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .byte_data(byte_data), .ev_ack(ev_ack),
        .ev_nack(ev_nack), .fetch_addr(fetch_addr), .rd_valid(rd_valid),
        .bus_idle(bus_idle)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one event for one cycle starting at a falling edge; return at the
    // next falling edge, where registered outputs already reflect it.
    task automatic send(input int kind, input logic [7:0] d = 8'h00);
        ev_start  = (kind == 1);
        ev_stop   = (kind == 2);
        ev_byte   = (kind == 3);
        ev_ack    = (kind == 4);
        ev_nack   = (kind == 5);
        byte_data = d;
        @(negedge clk);
        {ev_start, ev_stop, ev_byte, ev_ack, ev_nack} = '0;
    endtask

    task automatic set_addr(input int a, input logic [4:0] junk);
        send(1);
        send(3, {ID, 1'b0});
        send(3, {junk, 3'(a >> 8)});
        send(3, 8'(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 idle in reset", bus_idle, 1);
        chk("R1 valid in reset", rd_valid, 0);
        chk("R1 addr in reset", fetch_addr, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle after reset", bus_idle, 1);
        chk("R1 addr after reset", fetch_addr, 0);

        // R2 R7: random read to every address, junk in the unused high bits
        for (int a = 0; a <= TOP; a++) begin
            set_addr(a, 5'(a * 7 + 3));
            send(1);
            send(3, {ID, 1'b1});
            chk("R2 random read valid", rd_valid, 1);
            chk("R7 random read addr", fetch_addr, a);
        end
        exp_ptr = TOP;
        send(2);

        // R11: pulse lasts one cycle
        send(1);
        send(3, {ID, 1'b1});
        chk("R4 current read valid", rd_valid, 1);
        chk("R4 current read addr", fetch_addr, exp_ptr);
        @(negedge clk);
        chk("R11 pulse single cycle", rd_valid, 0);
        send(5);
        exp_ptr = (exp_ptr + 1) & TOP;
        chk("R5 wrap by nack", fetch_addr, exp_ptr);
        send(2);

        // R3: set-address only, then current read
        set_addr(12'h7F0, 5'h1F);
        send(2);
        chk("R3 idle after set", bus_idle, 1);
        chk("R3 no fetch on set", rd_valid, 0);
        exp_ptr = 12'h7F0;
        send(1);
        send(3, {ID, 1'b1});
        chk("R3 read from set addr", fetch_addr, exp_ptr);
        chk("R3 read valid", rd_valid, 1);

        // R5: sequential read across the top of the array
        for (int i = 1; i <= 40; i++) begin
            send(4);
            exp_ptr = (exp_ptr + 1) & TOP;
            chk("R5 sequential valid", rd_valid, 1);
            chk("R5 sequential addr", fetch_addr, exp_ptr);
        end

        // R6: nack ends the read, later acks ignored
        send(5);
        exp_ptr = (exp_ptr + 1) & TOP;
        chk("R6 nack no fetch", rd_valid, 0);
        chk("R6 nack advances", fetch_addr, exp_ptr);
        send(4);
        chk("R6 ack after nack ignored", rd_valid, 0);
        chk("R6 ack after nack addr", fetch_addr, exp_ptr);
        send(2);
        chk("R10 idle after stop", bus_idle, 1);
        send(1);
        send(3, {ID, 1'b1});
        chk("R6 continue addr", fetch_addr, exp_ptr);
        chk("R6 continue valid", rd_valid, 1);
        send(5);
        exp_ptr = (exp_ptr + 1) & TOP;
        send(2);

        // R8: start after only the high byte drops the operation
        send(1);
        send(3, {ID, 1'b0});
        send(3, 8'h05);
        send(1);
        send(3, {ID, 1'b1});
        chk("R8 dropped addr", fetch_addr, exp_ptr);
        chk("R8 read valid", rd_valid, 1);
        send(5);
        exp_ptr = (exp_ptr + 1) & TOP;
        send(2);

        // R9: foreign target byte
        for (int k = 0; k < 128; k++) begin
            if (7'(k) != ID) begin
                send(1);
                send(3, {7'(k), 1'(k)});
                chk("R9 foreign idle", bus_idle, 1);
                chk("R9 foreign no fetch", rd_valid, 0);
                chk("R9 foreign addr", fetch_addr, exp_ptr);
            end
        end

        // R10: idle ignores bytes, acks, nacks, stops
        send(3, {ID, 1'b1});
        chk("R10 byte ignored", rd_valid, 0);
        send(4);
        chk("R10 ack ignored", rd_valid, 0);
        send(5);
        chk("R10 nack ignored addr", fetch_addr, exp_ptr);
        send(2);
        chk("R10 still idle", bus_idle, 1);
        send(1);
        chk("R10 start leaves idle", bus_idle, 0);
        send(3, {ID, 1'b1});
        chk("R10 read after idle", fetch_addr, exp_ptr);
        send(2);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule